// File: doc/BRIEF.md
# Time-Scheduled Square-Wave Pin Generator

This block drives one output pin with a square wave of equal high and low time. The wave is tied to a free-running time counter kept elsewhere in the chip. Software loads two values: a start time, in the same tick units as that counter, and a half-period, which is the number of ticks between two consecutive edges. The output frequency is therefore one over twice the half-period. With 8 ns ticks, a half-period of N gives 1e9 / (N × 16) Hz. The 32-bit half-period sets the longest period at about 68.7 s.

A start pulse arms the generator only if the loaded start time is strictly later than the current time. Once armed, the pin rises when the time counter reaches the start time. After that it toggles every half-period. Each edge time is computed from the time base, not from a local cycle count, so the wave stays aligned when the counter steps by more than one tick per clock. A stop pulse forces the pin low and drops the schedule. A valid start given while the generator is already running re-arms it from the new start time. There is one channel.

Top module: `sched_pin_gen`

## Requirements
- R1: During and after synchronous reset, with no command given, `pin_out` and `running` are 0.
- R2: A `cmd_start` pulse with `start_time` > `time_now` (unsigned) and no `cmd_stop` sets `running` to 1 and `pin_out` to 0 in the next cycle.
- R3: A `cmd_start` pulse with `start_time` <= `time_now`, equality included, has no effect. `running`, `pin_out` and any schedule already in progress are left unchanged.
- R4: When armed with start time S, the first edge of `pin_out` is a rise. It appears in the cycle after the first clock edge at which `time_now` >= S, whether or not `time_now` equals S exactly.
- R5: While running with start S and half-period D, after the clock edge that samples time t, `pin_out` equals the parity of the count of k >= 0 with S + k·D <= t. This holds whenever the time advances by at most D per clock.
- R6: A `cmd_stop` pulse sets `pin_out` and `running` to 0 in the next cycle. No further edges follow until a new start is accepted.
- R7: A valid `cmd_start` while running drops the old schedule. In the next cycle the pin is low, and edges then follow R4 and R5 for the new start time.
- R8: When `cmd_start` and `cmd_stop` are given in the same cycle, the stop wins.
- R9: While `running` is 0, `pin_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Current value of the time counter, in ticks |
| start_time | input | 64 | Programmed time of the first rising edge |
| half_dur | input | 32 | Ticks between two consecutive edges |
| cmd_start | input | 1 | One-cycle request to arm the generator |
| cmd_stop | input | 1 | One-cycle request to stop and clear the schedule |
| pin_out | output | 1 | Square-wave output level |
| running | output | 1 | High while a schedule is armed |

## Verification
The assertions are checked on every cycle. They cover the command effects: arming on a future start, ignoring a late start, re-arming while running, stop priority, and the pin staying low while idle. Only the bench scenarios can show that the edges land at the right times. The bench sweeps half-periods from 1 to 4 ticks and every time step up to the half-period, so inexact matches with the start time occur. In each case it compares the pin against the edge count computed arithmetically from the start time.

// File: rtl/sched_pin_pkg.sv
package sched_pin_pkg;
    localparam int TICK_W = 64;
    localparam int SPAN_W = 32;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_ARM  = 2'd1,
        ACT_HALT = 2'd2
    } sched_act_e;

    typedef struct packed {
        logic running;
        logic fire;
    } sched_state_t;
endpackage

// File: rtl/sched_cmd_decode.sv
module sched_cmd_decode
    import sched_pin_pkg::*;
#(
    parameter int TIME_W = TICK_W
) (
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic [TIME_W-1:0] start_time,
    input  logic [TIME_W-1:0] time_now,
    output sched_act_e        act
);
    logic in_future;

    always_comb begin
        in_future = (start_time > time_now);
        if (cmd_stop)
            act = ACT_HALT;
        else if (cmd_start && in_future)
            act = ACT_ARM;
        else
            act = ACT_NONE;
    end
endmodule

// File: rtl/sched_edge_timer.sv
module sched_edge_timer
    import sched_pin_pkg::*;
#(
    parameter int TIME_W = TICK_W,
    parameter int DUR_W  = SPAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  sched_act_e        act,
    input  logic [TIME_W-1:0] time_now,
    input  logic [TIME_W-1:0] start_time,
    input  logic [DUR_W-1:0]  half_dur,
    output sched_state_t      st
);
    logic [TIME_W-1:0] next_edge_q;
    logic              running_q;
    logic              due;

    always_comb begin
        due        = running_q && (act == ACT_NONE) && (time_now >= next_edge_q);
        st.running = running_q;
        st.fire    = due;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q   <= 1'b0;
            next_edge_q <= '0;
        end else begin
            unique case (act)
                ACT_HALT: begin
                    running_q   <= 1'b0;
                    next_edge_q <= '0;
                end
                ACT_ARM: begin
                    running_q   <= 1'b1;
                    next_edge_q <= start_time;
                end
                default: begin
                    if (due)
                        next_edge_q <= next_edge_q + TIME_W'(half_dur);
                end
            endcase
        end
    end
endmodule

// File: rtl/sched_pin_toggle.sv
module sched_pin_toggle
    import sched_pin_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sched_act_e act,
    input  logic       fire,
    output logic       pin
);
    always_ff @(posedge clk) begin
        if (rst)
            pin <= 1'b0;
        else if (act != ACT_NONE)
            pin <= 1'b0;
        else if (fire)
            pin <= ~pin;
    end
endmodule

// File: rtl/sched_pin_gen.sv
module sched_pin_gen
    import sched_pin_pkg::*;
#(
    parameter int TIME_W = TICK_W,
    parameter int DUR_W  = SPAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] time_now,
    input  logic [TIME_W-1:0] start_time,
    input  logic [DUR_W-1:0]  half_dur,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    output logic              pin_out,
    output logic              running
);
    sched_act_e   act;
    sched_state_t st;

    sched_cmd_decode #(.TIME_W(TIME_W)) u_dec (
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .start_time(start_time),
        .time_now  (time_now),
        .act       (act)
    );

    sched_edge_timer #(.TIME_W(TIME_W), .DUR_W(DUR_W)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .time_now  (time_now),
        .start_time(start_time),
        .half_dur  (half_dur),
        .st        (st)
    );

    sched_pin_toggle u_pin (
        .clk (clk),
        .rst (rst),
        .act (act),
        .fire(st.fire),
        .pin (pin_out)
    );

    assign running = st.running;

    // R2
    arm_future_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !cmd_stop && (start_time > time_now)) |=> (running && !pin_out));

    // R3
    late_start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !cmd_stop && (start_time <= time_now) && !running) |=> !running);

    // R6
    stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_stop |=> (!running && !pin_out));

    // R7
    rearm_low_chk: assert property (@(posedge clk) disable iff (rst)
        (running && pin_out && cmd_start && !cmd_stop && (start_time > time_now)) |=> !pin_out);

    // R9
    idle_pin_low_chk: assert property (@(posedge clk) disable iff (rst)
        !running |-> !pin_out);
endmodule

// File: tb/sched_pin_gen_test.sv
module sched_pin_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] tnow = 64'd0;
    logic [63:0] st_time = 64'd0;
    logic [31:0] hdur = 32'd1;
    logic        c_start = 1'b0;
    logic        c_stop = 1'b0;
    logic        pin_out;
    logic        running;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sched_pin_gen uut (
        .clk(clk), .rst(rst), .time_now(tnow), .start_time(st_time),
        .half_dur(hdur), .cmd_start(c_start), .cmd_stop(c_stop),
        .pin_out(pin_out), .running(running)
    );

    function automatic logic exp_pin(input logic [63:0] t, input logic [63:0] s,
                                     input logic [63:0] d);
        logic [63:0] n;
        if (t < s) return 1'b0;
        n = (t - s) / d + 64'd1;
        return n[0];
    endfunction

    task automatic chk(input logic act, input logic expv, input string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0d", tag, act, expv, tnow);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] s;
        #2;
        repeat (3) cyc();
        chk(pin_out, 1'b0, "R1 pin in reset");
        chk(running, 1'b0, "R1 running in reset");
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tnow = tnow + 64'd1;
            cyc();
            chk(pin_out, 1'b0, "R1 pin after reset");
            chk(running, 1'b0, "R1 running after reset");
        end

        // R3: equal and past start times while idle
        tnow = 64'd50; st_time = 64'd50; c_start = 1'b1;
        cyc();
        chk(running, 1'b0, "R3 equal start ignored");
        st_time = 64'd45;
        cyc();
        chk(running, 1'b0, "R3 past start ignored");
        chk(pin_out, 1'b0, "R3 pin stays low");
        c_start = 1'b0;

        // R4 R5 R6 R9: sweep half-periods and time steps
        for (int d = 1; d <= 4; d++) begin
            for (int stp = 1; stp <= d; stp++) begin
                for (int off = 1; off <= 2; off++) begin
                    tnow = tnow + 64'd7;
                    hdur = 32'(d);
                    s = tnow + 64'(off);
                    st_time = s; c_start = 1'b1;
                    cyc();
                    c_start = 1'b0;
                    chk(running, 1'b1, "R2 armed");
                    chk(pin_out, 1'b0, "R2 armed low");
                    for (int k = 0; k < 14; k++) begin
                        tnow = tnow + 64'(stp);
                        cyc();
                        chk(pin_out, exp_pin(tnow, s, 64'(d)), "R5 edge schedule");
                    end
                    c_stop = 1'b1;
                    cyc();
                    c_stop = 1'b0;
                    chk(pin_out, 1'b0, "R6 stop pin low");
                    chk(running, 1'b0, "R6 stop not running");
                    for (int k = 0; k < 3; k++) begin
                        tnow = tnow + 64'(stp);
                        cyc();
                        chk(pin_out, 1'b0, "R9 idle pin low");
                    end
                end
            end
        end

        // R4: step jumps past the start time without hitting it exactly
        hdur = 32'd5; tnow = 64'd1000; s = 64'd1003; st_time = s; c_start = 1'b1;
        cyc();
        c_start = 1'b0;
        tnow = 64'd1002;
        cyc();
        chk(pin_out, 1'b0, "R4 before start");
        tnow = 64'd1004;
        cyc();
        chk(pin_out, 1'b1, "R4 first edge high on overshoot");

        // R3 while running: late start leaves schedule alone
        for (int k = 0; k < 3; k++) begin
            tnow = tnow + 64'd2;
            cyc();
        end
        st_time = tnow - 64'd1; c_start = 1'b1;
        tnow = tnow + 64'd2;
        cyc();
        c_start = 1'b0;
        chk(running, 1'b1, "R3 running kept");
        chk(pin_out, exp_pin(tnow, s, 64'd5), "R3 schedule kept");
        for (int k = 0; k < 6; k++) begin
            tnow = tnow + 64'd2;
            cyc();
            chk(pin_out, exp_pin(tnow, s, 64'd5), "R3 schedule continues");
        end

        // R7: re-arm while running
        while (pin_out !== 1'b1) begin
            tnow = tnow + 64'd1;
            cyc();
        end
        s = tnow + 64'd4; st_time = s; c_start = 1'b1; hdur = 32'd3;
        cyc();
        c_start = 1'b0;
        chk(pin_out, 1'b0, "R7 rearm low");
        chk(running, 1'b1, "R7 rearm running");
        for (int k = 0; k < 12; k++) begin
            tnow = tnow + 64'd1;
            cyc();
            chk(pin_out, exp_pin(tnow, s, 64'd3), "R7 new schedule");
        end

        // R8: simultaneous start and stop
        st_time = tnow + 64'd10; c_start = 1'b1; c_stop = 1'b1;
        cyc();
        c_start = 1'b0; c_stop = 1'b0;
        chk(running, 1'b0, "R8 stop wins running");
        chk(pin_out, 1'b0, "R8 stop wins pin");
        for (int k = 0; k < 15; k++) begin
            tnow = tnow + 64'd1;
            cyc();
            chk(pin_out, 1'b0, "R8 no edges after");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule